// File: doc/BRIEF.md
# Running Baseline and Noise Tracker

This block follows the quiet level (pedestal) of a digitised detector channel and the spread of the noise around it. Unsigned ADC samples arrive one per clock, each marked by a valid strobe. Every sample that is taken in moves an exponential-style running sum toward the sample. A second running sum tracks the squared distance of each sample from the current baseline. Both sums are divided by a power-of-two averaging length, so the baseline and the variance come out of a plain right shift. A hit detector placed next to the block drives an exclude input while a pulse is present. Samples marked this way leave all state untouched, so pulses never pull the baseline upward.

The sequence starts from an empty state after reset. The first sample taken in seeds the pedestal sum directly (the sample times N), so the baseline is correct at once and does not ramp up from zero. A control state machine then counts the accepted samples. It raises a flag when the baseline has had time to settle, and after a further equal stretch it raises a second flag for the variance. The variance settles later because its input uses the baseline. The states are ST_EMPTY (no sample yet), ST_WARM_BASE (baseline settling), ST_WARM_VAR (baseline settled, variance settling) and ST_SETTLED. The transitions are: ST_EMPTY to ST_WARM_BASE on the first accepted sample; ST_WARM_BASE to ST_WARM_VAR when the 8·N-th accepted sample is taken, counting the seed sample; ST_WARM_VAR to ST_SETTLED when a further 8·N accepted samples have been taken. ST_SETTLED holds until reset. With the defaults (12-bit samples, shift 4, N = 16) each stretch is 128 samples.

Top module: `baseline_noise_tracker`

## Requirements
- R1: While reset is held low and immediately after it, baseline and variance read 0 and both settled flags are low.
- R2: The first accepted sample after reset loads the pedestal sum with the sample shifted left by SHIFT_N and clears the variance sum. On the next clock the baseline equals that sample and the variance is 0.
- R3: Each later accepted sample s adds (s − baseline) to the pedestal sum, using signed arithmetic. The baseline output is the pedestal sum shifted right by SHIFT_N.
- R4: Each later accepted sample adds (s − baseline)² − variance to the variance sum, using the baseline from before the update, and clamps the result at zero. The variance output is the variance sum shifted right by SHIFT_N.
- R5: A sample with valid high and exclude high changes neither sum, the counter nor the state. This applies in ST_EMPTY too, where such a sample does not seed the baseline.
- R6: A cycle with valid low leaves both outputs and both flags unchanged.
- R7: baseline_settled goes high one clock after the 8·N-th accepted sample since reset, counting the seed sample, and stays high.
- R8: variance_settled goes high one clock after the 8·N-th accepted sample that follows the rise of baseline_settled. It is never high while baseline_settled is low.
- R9: If the same value is fed in continuously after seeding, the baseline stays at that value and the variance stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Unsigned ADC sample |
| smp_exclude | input | 1 | Sample belongs to a pulse; do not learn from it |
| baseline | output | SAMPLE_W | Pedestal sum shifted right by SHIFT_N |
| baseline_settled | output | 1 | Baseline settling stretch complete |
| variance | output | 2·SAMPLE_W | Variance sum shifted right by SHIFT_N |
| variance_settled | output | 1 | Variance settling stretch complete |

## Verification
Two functions can fall in the same cycle: the exclusion of a pulse sample and the settle counter reaching its limit. The bench runs the count to one short of 8·N and then offers an excluded sample. It checks that baseline_settled stays low and that the baseline and variance do not move. The following accepted sample must then raise the flag on the next clock. The same collision is tested in ST_EMPTY, where an excluded first sample must not seed the baseline. Every other cycle is judged against a bench model of the update rules, fed by pseudo-random noise and then by a step in level.

// File: rtl/bnt_pkg.sv
package bnt_pkg;

    // Control sequence of the tracker
    typedef enum logic [1:0] {
        ST_EMPTY     = 2'd0,
        ST_WARM_BASE = 2'd1,
        ST_WARM_VAR  = 2'd2,
        ST_SETTLED   = 2'd3
    } bnt_state_e;

endpackage

// File: rtl/bnt_ctrl.sv
module bnt_ctrl
    import bnt_pkg::*;
#(
    parameter int SHIFT_N     = 4,
    parameter int SETTLE_MULT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic load,
    output logic upd,
    output logic base_settled,
    output logic var_settled
);
    localparam int LIMIT = SETTLE_MULT * (1 << SHIFT_N);
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    bnt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (accept) begin
            unique case (state_q)
                ST_EMPTY: begin
                    state_d = ST_WARM_BASE;
                    cnt_d   = CW'(1);
                end
                ST_WARM_BASE: begin
                    if (cnt_q == LAST) begin
                        state_d = ST_WARM_VAR;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_WARM_VAR: begin
                    if (cnt_q == LAST) begin
                        state_d = ST_SETTLED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_SETTLED: begin
                    cnt_d = cnt_q;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        load         = 1'b0;
        upd          = 1'b0;
        base_settled = 1'b0;
        var_settled  = 1'b0;
        unique case (state_q)
            ST_EMPTY:     load = accept;
            ST_WARM_BASE: upd  = accept;
            ST_WARM_VAR: begin
                upd          = accept;
                base_settled = 1'b1;
            end
            ST_SETTLED: begin
                upd          = accept;
                base_settled = 1'b1;
                var_settled  = 1'b1;
            end
        endcase
    end

    // R7
    base_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(base_settled) |-> $past(accept));

    // R8
    var_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        var_settled |-> base_settled);

    // R5
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(cnt_q) && $stable(state_q)));

endmodule

// File: rtl/bnt_ped_acc.sv
module bnt_ped_acc #(
    parameter int SAMPLE_W = 12,
    parameter int SHIFT_N  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       upd,
    input  logic [SAMPLE_W-1:0]        sample,
    output logic [SAMPLE_W-1:0]        baseline,
    output logic signed [SAMPLE_W:0]   dev
);
    localparam int AW = SAMPLE_W + SHIFT_N;

    logic [AW-1:0]      acc_q, acc_d;
    logic signed [AW:0] sum;

    assign baseline = acc_q[AW-1:SHIFT_N];
    assign dev      = $signed({1'b0, sample}) - $signed({1'b0, baseline});

    always_comb begin
        sum   = $signed({1'b0, acc_q}) + $signed({{SHIFT_N{dev[SAMPLE_W]}}, dev});
        acc_d = acc_q;
        if (load)     acc_d = {sample, {SHIFT_N{1'b0}}};
        else if (upd) acc_d = sum[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R2
    seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (baseline == $past(sample)));

    // R3
    upward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && dev > 0) |=> (baseline >= $past(baseline)));

    // R5
    ped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !load) |=> $stable(acc_q));

endmodule

// File: rtl/bnt_var_acc.sv
module bnt_var_acc #(
    parameter int SAMPLE_W = 12,
    parameter int SHIFT_N  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      upd,
    input  logic signed [SAMPLE_W:0]  dev,
    output logic [2*SAMPLE_W-1:0]     variance
);
    localparam int VW = 2 * SAMPLE_W + SHIFT_N;
    localparam int QW = 2 * SAMPLE_W + 2;

    logic [VW-1:0]        acc_q, acc_d;
    logic signed [QW-1:0] dev_x, sq;
    logic signed [VW+1:0] nxt;

    assign variance = acc_q[VW-1:SHIFT_N];

    always_comb begin
        dev_x = {{(SAMPLE_W + 1){dev[SAMPLE_W]}}, dev};
        sq    = dev_x * dev_x;
        nxt   = $signed({2'b00, acc_q})
              + $signed({{SHIFT_N{sq[QW-1]}}, sq})
              - $signed({{(SHIFT_N + 2){1'b0}}, variance});
        acc_d = acc_q;
        if (load)     acc_d = '0;
        else if (upd) acc_d = nxt[VW+1] ? '0 : nxt[VW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R2
    var_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (variance == '0));

    // R9
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && dev == 0 && variance == '0) |=> (variance == '0));

    // R5
    var_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !load) |=> $stable(acc_q));

endmodule

// File: rtl/baseline_noise_tracker.sv
module baseline_noise_tracker #(
    parameter int SAMPLE_W    = 12,
    parameter int SHIFT_N     = 4,
    parameter int SETTLE_MULT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [SAMPLE_W-1:0]     smp_data,
    input  logic                    smp_exclude,
    output logic [SAMPLE_W-1:0]     baseline,
    output logic                    baseline_settled,
    output logic [2*SAMPLE_W-1:0]   variance,
    output logic                    variance_settled
);
    logic                    accept, load, upd;
    logic signed [SAMPLE_W:0] dev;

    assign accept = smp_valid & ~smp_exclude;

    bnt_ctrl #(
        .SHIFT_N    (SHIFT_N),
        .SETTLE_MULT(SETTLE_MULT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .load        (load),
        .upd         (upd),
        .base_settled(baseline_settled),
        .var_settled (variance_settled)
    );

    bnt_ped_acc #(
        .SAMPLE_W(SAMPLE_W),
        .SHIFT_N (SHIFT_N)
    ) u_ped (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .upd     (upd),
        .sample  (smp_data),
        .baseline(baseline),
        .dev     (dev)
    );

    bnt_var_acc #(
        .SAMPLE_W(SAMPLE_W),
        .SHIFT_N (SHIFT_N)
    ) u_var (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .upd     (upd),
        .dev     (dev),
        .variance(variance)
    );

    // R6
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(baseline) && $stable(variance)
                        && $stable(baseline_settled) && $stable(variance_settled)));

endmodule

// File: tb/baseline_noise_tracker_bench.sv
module baseline_noise_tracker_bench;
    localparam int W     = 12;
    localparam int SH    = 4;
    localparam int LIMIT = 8 * (1 << SH);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            smp_valid = 1'b0;
    logic [W-1:0]    smp_data = '0;
    logic            smp_exclude = 1'b0;
    logic [W-1:0]    baseline;
    logic            baseline_settled;
    logic [2*W-1:0]  variance;
    logic            variance_settled;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model of the requirements
    longint m_ped = 0, m_var = 0;
    int     m_state = 0, m_cnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    baseline_noise_tracker #(.SAMPLE_W(W), .SHIFT_N(SH), .SETTLE_MULT(8)) u_baseline_noise_tracker (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_exclude(smp_exclude), .baseline(baseline), .baseline_settled(baseline_settled),
        .variance(variance), .variance_settled(variance_settled)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step(input bit v, input bit x, input int s);
        longint b, vo, d;
        if (v && !x) begin
            if (m_state == 0) begin
                m_ped = longint'(s) << SH; m_var = 0; m_state = 1; m_cnt = 1;
            end else begin
                b = m_ped >>> SH; vo = m_var >>> SH; d = longint'(s) - b;
                m_ped = m_ped + d;
                m_var = m_var + d * d - vo;
                if (m_var < 0) m_var = 0;
                if (m_state != 3) begin
                    m_cnt++;
                    if (m_cnt == LIMIT) begin
                        m_state = m_state + 1; m_cnt = 0;
                    end
                end
            end
        end
    endtask

    task automatic compare(input string tag);
        chk(baseline == W'(m_ped >>> SH), {tag, " baseline"}, baseline, m_ped >>> SH);
        chk(variance == (2*W)'(m_var >>> SH), {tag, " variance"}, variance, m_var >>> SH);
        chk(baseline_settled == (m_state >= 2), {tag, " baseline_settled"}, baseline_settled, m_state >= 2);
        chk(variance_settled == (m_state == 3), {tag, " variance_settled"}, variance_settled, m_state == 3);
    endtask

    // called at a falling edge; leaves time at the next falling edge
    task automatic step(input bit v, input bit x, input int s, input string tag);
        smp_valid = v; smp_exclude = x; smp_data = W'(s);
        @(posedge clk);
        model_step(v, x, s);
        @(negedge clk);
        smp_valid = 1'b0; smp_exclude = 1'b0;
        compare(tag);
    endtask

    function automatic int noise(input int centre);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return centre + int'(lfsr % 41) - 20;
    endfunction

    task automatic t_reset;
        @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");
    endtask

    task automatic t_seed;
        step(1'b1, 1'b1, 3000, "R5 excluded before seed");
        chk(baseline == 0, "R5 no seed from excluded", baseline, 0);
        step(1'b0, 1'b0, 2500, "R6 valid low before seed");
        step(1'b1, 1'b0, 1000, "R2 seed");
        chk(baseline == 1000, "R2 seed value", baseline, 1000);
        chk(variance == 0, "R2 seed variance", variance, 0);
    endtask

    task automatic t_constant;
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1000, "R9 constant");
        chk(baseline == 1000 && variance == 0, "R9 flat input", variance, 0);
    endtask

    task automatic t_noise_to_base_settle;
        while (m_state == 1 && m_cnt < LIMIT - 1) step(1'b1, 1'b0, noise(1000), "R3 R4 noise");
        chk(baseline_settled == 1'b0, "R7 not yet settled", baseline_settled, 0);
        step(1'b1, 1'b1, 3900, "R5 R7 excluded at limit");
        chk(baseline_settled == 1'b0, "R7 excluded does not count", baseline_settled, 0);
        step(1'b0, 1'b0, 1000, "R6 idle at limit");
        step(1'b1, 1'b0, noise(1000), "R7 final sample");
        chk(baseline_settled == 1'b1, "R7 settled", baseline_settled, 1);
        chk(variance_settled == 1'b0, "R8 variance still warming", variance_settled, 0);
    endtask

    task automatic t_var_settle;
        while (m_state == 2 && m_cnt < LIMIT - 1) step(1'b1, 1'b0, noise(1000), "R4 noise");
        chk(variance_settled == 1'b0, "R8 one short", variance_settled, 0);
        step(1'b1, 1'b1, 4000, "R5 R8 excluded at limit");
        chk(variance_settled == 1'b0, "R8 excluded does not count", variance_settled, 0);
        step(1'b1, 1'b0, noise(1000), "R8 final sample");
        chk(variance_settled == 1'b1, "R8 settled", variance_settled, 1);
        chk(variance > 0, "R4 noise gives variance", variance, 1);
    endtask

    task automatic t_pulse_and_step;
        logic [W-1:0]   b0;
        logic [2*W-1:0] v0;
        b0 = baseline; v0 = variance;
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 3500 + i * 50, "R5 pulse");
        chk(baseline == b0, "R5 pulse baseline", baseline, b0);
        chk(variance == v0, "R5 pulse variance", variance, v0);
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, noise(2000), "R3 R4 level step");
        chk(baseline > b0, "R3 baseline follows step", baseline, b0);
        step(1'b0, 1'b0, 0, "R6 idle settled");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_seed();
        t_constant();
        t_noise_to_base_settle();
        t_var_settle();
        t_pulse_and_step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule